// File: doc/BRIEF.md
# Core Clock Frequency Feedback Meter

This block reports the average rate at which a core has really been clocked during an observation window. Two free-running counters sit side by side. One advances on every tick of a fixed 408 MHz reference. The other advances only in cycles where the core is genuinely clocking. Both can be read at any time as a single packed 64-bit feedback word. In this model the core clock and the reference clock are both same-domain enables on the measurement clock.

A measurement starts with a pulse on `start_i`. The sequencer snapshots the feedback word and waits a programmed number of cycles. It then snapshots the word again and forms both deltas using modulo arithmetic, so a counter wrap inside the window gives the exact count. If either delta is zero it returns 0. Otherwise it computes `core_delta * 408 / ref_delta` in MHz on a multicycle restoring divider and reports that figure times 1000 as kHz, with a one-cycle `result_valid_o` pulse.

Short windows give a quick first reading. Long windows give a smoother average.

Top module: `freq_feedback_meter`

## Requirements
- R1: After reset both counters read zero. `feedback_o[CNT_W-1:0]` holds the reference counter and `feedback_o[2*CNT_W-1:CNT_W]` holds the core-cycle counter.
- R2: The reference counter increases by one on each clock where `ref_en_i` is 1 and otherwise holds. The core counter does the same with `core_active_i`.
- R3: With `window_i` = W, the two snapshots are taken max(W,1) clock cycles apart. The first is taken on the edge that accepts `start_i`.
- R4: The result on `freq_khz_o` is floor(core_delta * 408 / ref_delta) * 1000.
- R5: A delta that crosses the counter wrap equals (second - first) mod 2^CNT_W.
- R6: A core-cycle delta of zero gives a result of 0.
- R7: A reference delta of zero (idle reference) gives a result of 0.
- R8: Each measurement ends with exactly one single-cycle `result_valid_o` pulse. `busy_o` is 1 from the cycle after the start edge until that pulse, and 0 in the pulse cycle.
- R9: `start_i` has no effect while `busy_o` is 1.
- R10: `clear_i` zeroes both counters and abandons any measurement in flight, with no `result_valid_o` pulse. One cycle later `busy_o` is 0.
- R11: The product core_delta * 408 is formed at CNT_W+9 bits, so a ratio near full scale yields the exact quotient.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Measurement clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of counters and sequencer |
| ref_en_i | input | 1 | Reference tick enable (408 MHz tick) |
| core_active_i | input | 1 | Core is clocking this cycle |
| start_i | input | 1 | Begin a measurement when idle |
| window_i | input | WIN_W | Cycles between the two snapshots |
| feedback_o | output | 2*CNT_W | Packed {core counter, reference counter} |
| busy_o | output | 1 | Measurement in progress |
| result_valid_o | output | 1 | One-cycle result strobe |
| freq_khz_o | output | CNT_W+19 | Measured rate in kHz |

## Verification
The assertions check the following on every cycle:
- the per-cycle counter steps and holds;
- that a clear empties the counters and the sequencer on the next edge;
- that the result strobe lasts one cycle;
- that every fall of `busy_o` outside a clear coincides with a result.

Only the bench scenarios can show the values that need a whole window:
- the window spacing;
- the exact kHz figure under several core-activity patterns;
- the zero-delta cases;
- the wrap, shown on a narrow-counter instance;
- that a start arriving mid-measurement leaves the running window untouched.

// File: rtl/ffm_pkg.sv
package ffm_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_CALC, ST_DIV} meas_state_e;
  localparam int unsigned REF_MHZ     = 408;
  localparam int unsigned KHZ_PER_MHZ = 1000;
  localparam int unsigned MUL_EXTRA_W = 9;   // 408 < 2^9
  localparam int unsigned KHZ_EXTRA_W = 10;  // 1000 < 2^10
endpackage

// File: rtl/ffm_counters.sv
module ffm_counters #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             ref_en_i,
  input  logic             core_en_i,
  output logic [CNT_W-1:0] ref_cnt_o,
  output logic [CNT_W-1:0] core_cnt_o
);
  localparam int unsigned LANES = 2;

  logic [LANES-1:0]            en;
  logic [LANES-1:0][CNT_W-1:0] cnt_q;

  assign en = {core_en_i, ref_en_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      for (int l = 0; l < LANES; l++) begin
        if (clear_i)    cnt_q[l] <= '0;
        else if (en[l]) cnt_q[l] <= cnt_q[l] + CNT_W'(1);
      end
    end
  end

  assign ref_cnt_o  = cnt_q[0];
  assign core_cnt_o = cnt_q[1];
endmodule

// File: rtl/ffm_divider.sv
module ffm_divider #(
  parameter int unsigned NUM_W = 41,
  parameter int unsigned DEN_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             done_o,
  output logic [NUM_W-1:0] quo_o
);
  localparam int unsigned CW = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] quo_q;
  logic [DEN_W-1:0] rem_q, den_q;
  logic [CW-1:0]    cnt_q;
  logic             run_q, done_q;
  logic [DEN_W:0]   shifted, diff;
  logic             fits;

  assign shifted = {rem_q, quo_q[NUM_W-1]};
  assign fits    = shifted >= {1'b0, den_q};
  assign diff    = shifted - {1'b0, den_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quo_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (clear_i) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !run_q) begin
        quo_q <= num_i;
        rem_q <= '0;
        den_q <= den_i;
        cnt_q <= CW'(NUM_W);
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= fits ? diff[DEN_W-1:0] : shifted[DEN_W-1:0];
        quo_q <= {quo_q[NUM_W-2:0], fits};
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quo_o  = quo_q;
endmodule

// File: rtl/freq_feedback_meter.sv
module freq_feedback_meter
  import ffm_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned WIN_W = 32,
  localparam int unsigned PROD_W = CNT_W + MUL_EXTRA_W,
  localparam int unsigned KHZ_W  = PROD_W + KHZ_EXTRA_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clear_i,
  input  logic               ref_en_i,
  input  logic               core_active_i,
  input  logic               start_i,
  input  logic [WIN_W-1:0]   window_i,
  output logic [2*CNT_W-1:0] feedback_o,
  output logic               busy_o,
  output logic               result_valid_o,
  output logic [KHZ_W-1:0]   freq_khz_o
);
  logic [CNT_W-1:0]  ref_cnt, core_cnt;
  logic [CNT_W-1:0]  s0_ref_q, s0_core_q, s1_ref_q, s1_core_q;
  logic [CNT_W-1:0]  d_ref, d_core;
  logic [WIN_W-1:0]  wait_q;
  logic [PROD_W-1:0] product, quo;
  logic              div_go, div_done, zero_delta;
  logic              valid_q;
  logic [KHZ_W-1:0]  khz_q;
  meas_state_e       state_q;

  ffm_counters #(.CNT_W(CNT_W)) u_counters (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (clear_i),
    .ref_en_i   (ref_en_i),
    .core_en_i  (core_active_i),
    .ref_cnt_o  (ref_cnt),
    .core_cnt_o (core_cnt)
  );

  // modulo subtraction is exact across one wrap
  assign d_ref      = s1_ref_q - s0_ref_q;
  assign d_core     = s1_core_q - s0_core_q;
  assign zero_delta = (d_ref == '0) || (d_core == '0);
  assign product    = PROD_W'(d_core) * PROD_W'(REF_MHZ);
  assign div_go     = (state_q == ST_CALC) && !zero_delta;

  ffm_divider #(.NUM_W(PROD_W), .DEN_W(CNT_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .start_i (div_go),
    .num_i   (product),
    .den_i   (d_ref),
    .done_o  (div_done),
    .quo_o   (quo)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      s0_ref_q  <= '0;
      s0_core_q <= '0;
      s1_ref_q  <= '0;
      s1_core_q <= '0;
      wait_q    <= '0;
      valid_q   <= 1'b0;
      khz_q     <= '0;
    end else if (clear_i) begin
      state_q <= ST_IDLE;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          s0_ref_q  <= ref_cnt;
          s0_core_q <= core_cnt;
          wait_q    <= window_i;
          state_q   <= ST_WAIT;
        end
        ST_WAIT: begin
          if (wait_q <= WIN_W'(1)) begin
            s1_ref_q  <= ref_cnt;
            s1_core_q <= core_cnt;
            state_q   <= ST_CALC;
          end else begin
            wait_q <= wait_q - WIN_W'(1);
          end
        end
        ST_CALC: begin
          if (zero_delta) begin
            khz_q   <= '0;
            valid_q <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_DIV;
          end
        end
        ST_DIV: if (div_done) begin
          khz_q   <= KHZ_W'(quo) * KHZ_W'(KHZ_PER_MHZ);
          valid_q <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign feedback_o     = {core_cnt, ref_cnt};
  assign busy_o         = (state_q != ST_IDLE);
  assign result_valid_o = valid_q;
  assign freq_khz_o     = khz_q;
endmodule

// File: rtl/ffm_checker.sv
module ffm_checker #(
  parameter int unsigned CNT_W = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               clear_i,
  input logic               ref_en_i,
  input logic               core_active_i,
  input logic [2*CNT_W-1:0] feedback_o,
  input logic               busy_o,
  input logic               result_valid_o
);
  logic [CNT_W-1:0] ref_f, core_f;
  assign ref_f  = feedback_o[CNT_W-1:0];
  assign core_f = feedback_o[2*CNT_W-1:CNT_W];

  assert_ref_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && ref_en_i) |=> (ref_f == $past(ref_f) + CNT_W'(1)));

  assert_core_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !core_active_i) |=> $stable(core_f));

  assert_valid_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |=> !result_valid_o);

  assert_busy_end_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_o) && !$past(clear_i)) |-> result_valid_o);

  assert_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (feedback_o == '0 && !busy_o && !result_valid_o));
endmodule

bind freq_feedback_meter ffm_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .clear_i        (clear_i),
  .ref_en_i       (ref_en_i),
  .core_active_i  (core_active_i),
  .feedback_o     (feedback_o),
  .busy_o         (busy_o),
  .result_valid_o (result_valid_o)
);

// File: tb/freq_feedback_meter_tb_top.sv
module freq_feedback_meter_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  CW   = 32;
  localparam int  CW_S = 8;
  localparam int  WDOG = 150000;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic clear_i = 1'b0;
  logic ref_en_i = 1'b0;
  logic core_active_i = 1'b0;
  logic start_i = 1'b0;
  logic [31:0] window_i = '0;

  logic [2*CW-1:0]   fb;
  logic [2*CW_S-1:0] fb_s;
  logic busy, busy_s, vld, vld_s;
  logic [CW+18:0]   khz;
  logic [CW_S+18:0] khz_s;

  int checks = 0, errors = 0, cycles = 0;
  int vcnt = 0, vcnt_s = 0;
  int core_mode = 0, ref_mode = 0, phase = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  freq_feedback_meter dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_i), .ref_en_i(ref_en_i),
    .core_active_i(core_active_i), .start_i(start_i), .window_i(window_i),
    .feedback_o(fb), .busy_o(busy), .result_valid_o(vld), .freq_khz_o(khz));

  freq_feedback_meter #(.CNT_W(CW_S)) small_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_i), .ref_en_i(ref_en_i),
    .core_active_i(core_active_i), .start_i(start_i), .window_i(window_i),
    .feedback_o(fb_s), .busy_o(busy_s), .result_valid_o(vld_s), .freq_khz_o(khz_s));

  // activity patterns, changed away from the active edge
  always @(negedge clk_i) begin
    phase <= phase + 1;
    lfsr  <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (core_mode)
      0: core_active_i <= 1'b0;
      1: core_active_i <= 1'b1;
      2: core_active_i <= (phase % 3 == 0);
      default: core_active_i <= lfsr[0];
    endcase
    case (ref_mode)
      0: ref_en_i <= 1'b0;
      1: ref_en_i <= 1'b1;
      default: ref_en_i <= (phase % 4 == 0);
    endcase
    if (vld)   vcnt   <= vcnt + 1;
    if (vld_s) vcnt_s <= vcnt_s + 1;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint ref_of(input bit sm);
    return sm ? longint'(fb_s[CW_S-1:0]) : longint'(fb[CW-1:0]);
  endfunction
  function automatic longint core_of(input bit sm);
    return sm ? longint'(fb_s[2*CW_S-1:CW_S]) : longint'(fb[2*CW-1:CW]);
  endfunction
  function automatic longint exp_khz(input longint dc, input longint dr);
    if (dc == 0 || dr == 0) return 0;
    return (dc * 408 / dr) * 1000;
  endfunction

  task automatic wait_idle();
    while (busy || busy_s) @(negedge clk_i);
  endtask

  task automatic measure(input int w, input int cm, input int rm, input bit sm, input string req);
    longint r0, c0, r1, c1, dr, dc, mask, got;
    int wp, v0, guard;
    core_mode = cm; ref_mode = rm;
    repeat (3) @(negedge clk_i);
    wp   = (w == 0) ? 1 : w;
    mask = sm ? ((64'd1 << CW_S) - 1) : ((64'd1 << CW) - 1);
    v0   = sm ? vcnt_s : vcnt;
    window_i = w; start_i = 1'b1;
    r0 = ref_of(sm); c0 = core_of(sm);
    for (int k = 1; k <= wp; k++) begin
      @(negedge clk_i);
      if (k == 1) begin
        start_i = 1'b0;
        check(sm ? busy_s : busy, "R8 busy after start", 0, 1);
      end
      if (k == wp) begin r1 = ref_of(sm); c1 = core_of(sm); end
    end
    dr = (r1 - r0) & mask; dc = (c1 - c0) & mask;
    if (rm == 1) check(dr == wp, "R3 window spacing", dr, wp);
    guard = 0;
    while (!(sm ? vld_s : vld) && guard < 400) begin @(negedge clk_i); guard++; end
    got = sm ? longint'(khz_s) : longint'(khz);
    check(got == exp_khz(dc, dr), req, got, exp_khz(dc, dr));
    check(!(sm ? busy_s : busy), "R8 busy low at result", 1, 0);
    repeat (3) @(negedge clk_i);
    check(((sm ? vcnt_s : vcnt) - v0) == 1, "R8 single pulse", (sm ? vcnt_s : vcnt) - v0, 1);
    wait_idle();
  endtask

  task automatic t_reset();
    check(fb == '0, "R1 counters zero", fb, 0);
    check(!busy && !vld, "R1 idle after reset", {busy, vld}, 0);
  endtask

  task automatic t_count();
    longint r0, c0;
    core_mode = 0; ref_mode = 1;
    @(negedge clk_i); @(negedge clk_i);
    r0 = ref_of(0); c0 = core_of(0);
    repeat (10) @(negedge clk_i);
    check(ref_of(0) - r0 == 10, "R2 ref counts in low half", ref_of(0) - r0, 10);
    check(core_of(0) == c0, "R2 core holds when inactive", core_of(0), c0);
    core_mode = 1; ref_mode = 0;
    @(negedge clk_i); @(negedge clk_i);
    r0 = ref_of(0); c0 = core_of(0);
    repeat (7) @(negedge clk_i);
    check(core_of(0) - c0 == 7, "R1 R2 core counts in high half", core_of(0) - c0, 7);
    check(ref_of(0) == r0, "R2 ref holds when disabled", ref_of(0), r0);
  endtask

  task automatic t_busy_ignore();
    int n = 0, v0;
    core_mode = 1; ref_mode = 1;
    repeat (2) @(negedge clk_i);
    v0 = vcnt;
    window_i = 60; start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    repeat (9) @(negedge clk_i);
    window_i = 3; start_i = 1'b1;      // R9: must be ignored
    @(negedge clk_i); start_i = 1'b0;
    n = 11;
    while (!vld && n < 400) begin @(negedge clk_i); n++; end
    check(n >= 60, "R9 late start ignored (cycles to result)", n, 60);
    check(khz == 408000, "R9 result of first window", khz, 408000);
    repeat (3) @(negedge clk_i);
    check(vcnt - v0 == 1, "R9 one result only", vcnt - v0, 1);
    wait_idle();
  endtask

  task automatic t_clear();
    int v0;
    core_mode = 1; ref_mode = 1;
    repeat (2) @(negedge clk_i);
    v0 = vcnt;
    window_i = 80; start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    repeat (10) @(negedge clk_i);
    clear_i = 1'b1;
    @(negedge clk_i); clear_i = 1'b0;
    check(fb == '0, "R10 counters cleared", fb, 0);
    check(!busy, "R10 measurement abandoned", busy, 0);
    repeat (200) @(negedge clk_i);
    check(vcnt == v0, "R10 no result after clear", vcnt - v0, 0);
  endtask

  task automatic t_wrap();
    longint c0;
    core_mode = 1; ref_mode = 1;
    while (core_of(1) < 200) @(negedge clk_i);
    c0 = core_of(1);
    measure(100, 1, 1, 1, "R5 wrapped deltas");
    check(core_of(1) < c0, "R5 counter wrapped", core_of(1), c0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_count();
    measure(100, 1, 1, 0, "R4 full activity");
    measure(90,  2, 1, 0, "R4 one core cycle in three");
    measure(37,  3, 1, 0, "R4 irregular core activity");
    measure(0,   1, 1, 0, "R3 R4 zero window acts as one");
    measure(50,  0, 1, 0, "R6 zero core delta");
    measure(50,  1, 0, 0, "R7 idle reference");
    measure(200, 1, 2, 0, "R11 high ratio exact");
    t_busy_ignore();
    t_clear();
    t_wrap();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk_i) begin
    cycles <= cycles + 1;
    if (cycles == WDOG) begin
      checks++; errors++;
      $display("FAIL watchdog actual %0d expected %0d", cycles, WDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule